// File: doc/BRIEF.md
# Clock Loss-of-Signal Monitor

This block watches a set of input clocks for missing pulses, using a free-running reference clock. Each input has its own monitor. A monitor passes the input through a two-flop synchroniser into the reference domain and finds its rising edges. It declares a fault when too many reference cycles go by without an edge. A fault raises that input's loss-of-signal alarm. The alarm is sticky: it clears only after the input has shown no fault for a whole validation period, and any fault during that period starts the period again from zero.

Each input has a 2-bit mode that turns monitoring off or picks one of two detection windows. One 2-bit select, shared by all inputs, picks the validation period in milliseconds. A shared prescaler divides the reference clock down to a millisecond tick, and its divide ratio is a parameter so that simulation can use a short tick. A registered summary alarm is high whenever any input alarm is high.

Top module: `clk_los_monitor`

## Requirements
- R1: In mode 11 (standard), a fault is declared when MISS_CYC reference cycles pass with no detected input edge. With a dead input, the alarm is high at the sample taken MISS_CYC+3 reference cycles after the last input rise, and low at the sample one cycle earlier.
- R2: In mode 10 (alternate), the window is 2*MISS_CYC cycles. The alarm rises 2*MISS_CYC+3 cycles after the last rise, and is still low at MISS_CYC+3.
- R3: In mode 00 (off) and mode 01 (reserved), the alarm is low from the next reference edge. Both counters are held at zero, so after monitoring is turned back on a dead input needs a full MISS_CYC window before the alarm rises.
- R4: Once set, the alarm stays high until the selected number of ticks has elapsed with no fault.
- R5: A fault while the validation period is running keeps the alarm high and restarts the period from zero.
- R6: Validation select: 00 = 2 ticks, 01 = 100 ticks, 10 = 200 ticks, 11 = 13000 ticks. One tick occurs every TICK_DIV reference cycles. After a fault, the alarm is still high after (n-1)*TICK_DIV cycles and low after n*TICK_DIV cycles.
- R7: After reset all alarms are low, and an input that keeps toggling faster than the window never raises its alarm.
- R8: The summary alarm equals the OR of the per-input alarms one reference cycle earlier. It stays high until every input alarm has cleared.
- R9: Inputs are monitored independently. A fault on one input does not change another input's alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_in | input | NUM_CH | Monitored input clocks, asynchronous to clk_ref |
| mode | input | 2*NUM_CH | Per-input mode, input i in bits [2i+1:2i] |
| valtime | input | 2 | Shared validation-period select |
| los_alarm | output | NUM_CH | Per-input sticky loss-of-signal alarm |
| alarm_any | output | 1 | Registered OR of all input alarms |

## Verification
The input rise reaches the alarm through two synchroniser flops, the edge-history flop, MISS_CYC counter cycles and the alarm register. The bench therefore records the cycle of every rise it drives and samples the alarm at exactly MISS_CYC+2 and MISS_CYC+3 cycles later (2*MISS_CYC for the alternate mode). The tick runs freely, so the clearing point is only known to within one tick. The bench checks the alarm high at (n-1)*TICK_DIV cycles after the observed fault and low at n*TICK_DIV cycles, for all four select codes. Mode changes take effect one cycle after they are driven. The summary output is compared on every cycle against the OR of the input alarms sampled one cycle before.

// File: rtl/clk_los_pkg.sv
package clk_los_pkg;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_RSVD = 2'b01,
      MODE_SLOW = 2'b10,
      MODE_FAST = 2'b11
   } los_mode_e;

   localparam int unsigned VAL_TICKS_MAX = 13000;
   localparam int unsigned VAL_W         = $clog2(VAL_TICKS_MAX + 1);

   // last count value of the validation timer for each select code
   function automatic logic [VAL_W-1:0] val_last(input logic [1:0] sel);
      logic [VAL_W-1:0] r;
      case (sel)
         2'b00:   r = VAL_W'(2 - 1);
         2'b01:   r = VAL_W'(100 - 1);
         2'b10:   r = VAL_W'(200 - 1);
         default: r = VAL_W'(VAL_TICKS_MAX - 1);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/los_tick_gen.sv
module los_tick_gen #(
   parameter int unsigned DIV = 1000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("los_tick_gen: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst)              cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);

         // ticks are single-cycle pulses spaced DIV cycles apart
         assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (rst)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/los_edge_sync.sv
module los_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("los_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   // STAGES synchroniser flops plus one history flop
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[STAGES-1:0], async_in};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

   assert_rise_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);
endmodule

// File: rtl/los_channel.sv
module los_channel
   import clk_los_pkg::*;
#(
   parameter int unsigned MISS_CYC = 64
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       rise,
   input  logic [1:0] mode,
   input  logic [1:0] valtime,
   output logic       alarm
);
   localparam int unsigned GAP_W = $clog2(2 * MISS_CYC + 1);
   localparam logic [GAP_W-1:0] GAP_FAST = GAP_W'(MISS_CYC - 1);
   localparam logic [GAP_W-1:0] GAP_SLOW = GAP_W'(2 * MISS_CYC - 1);

   generate
      if (MISS_CYC < 4) begin : g_bad
         $error("los_channel: MISS_CYC must be at least 4");
      end
   endgenerate

   los_mode_e        mode_e;
   logic             active;
   logic [GAP_W-1:0] gap_last;
   logic [GAP_W-1:0] gap_q;
   logic [VAL_W-1:0] val_q;
   logic             alarm_q;
   logic             fault;
   logic             val_done;

   assign mode_e   = los_mode_e'(mode);
   assign active   = (mode_e == MODE_FAST) || (mode_e == MODE_SLOW);
   assign gap_last = (mode_e == MODE_SLOW) ? GAP_SLOW : GAP_FAST;
   assign fault    = active && !rise && (gap_q == gap_last);
   assign val_done = tick && (val_q >= val_last(valtime));

   // missing-pulse window counter
   always_ff @(posedge clk) begin
      if (rst || !active || rise || fault) gap_q <= '0;
      else                                 gap_q <= gap_q + 1'b1;
   end

   // sticky alarm with restartable validation timer
   always_ff @(posedge clk) begin
      if (rst || !active) begin
         alarm_q <= 1'b0;
         val_q   <= '0;
      end else if (fault) begin
         alarm_q <= 1'b1;
         val_q   <= '0;
      end else if (!alarm_q) begin
         val_q   <= '0;
      end else if (val_done) begin
         alarm_q <= 1'b0;
         val_q   <= '0;
      end else if (tick) begin
         val_q   <= val_q + 1'b1;
      end
   end

   assign alarm = alarm_q;

   assert_fault_sets_R1: assert property (@(posedge clk) disable iff (rst)
      fault |=> alarm_q);

   assert_gap_bound_R2: assert property (@(posedge clk) disable iff (rst)
      gap_q <= GAP_SLOW);

   assert_off_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      !active |=> (!alarm_q && gap_q == '0 && val_q == '0));

   assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      (alarm_q && active && !val_done) |=> alarm_q);

   assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
      (alarm_q && fault) |=> (alarm_q && val_q == '0));
endmodule

// File: rtl/clk_los_monitor.sv
module clk_los_monitor
   import clk_los_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned MISS_CYC    = 64,
   parameter int unsigned TICK_DIV    = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk_ref,
   input  logic                  rst,
   input  logic [NUM_CH-1:0]     clk_in,
   input  logic [2*NUM_CH-1:0]   mode,
   input  logic [1:0]            valtime,
   output logic [NUM_CH-1:0]     los_alarm,
   output logic                  alarm_any
);
   generate
      if (NUM_CH < 1) begin : g_bad
         $error("clk_los_monitor: NUM_CH must be at least 1");
      end
   endgenerate

   logic             ms_tick;
   logic [NUM_CH-1:0] rise;

   los_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk_ref),
      .rst  (rst),
      .tick (ms_tick)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         los_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk_ref),
            .rst      (rst),
            .async_in (clk_in[i]),
            .rise     (rise[i])
         );

         los_channel #(.MISS_CYC(MISS_CYC)) u_mon (
            .clk     (clk_ref),
            .rst     (rst),
            .tick    (ms_tick),
            .rise    (rise[i]),
            .mode    (mode[2*i +: 2]),
            .valtime (valtime),
            .alarm   (los_alarm[i])
         );
      end
   endgenerate

   always_ff @(posedge clk_ref) begin
      if (rst) alarm_any <= 1'b0;
      else     alarm_any <= |los_alarm;
   end

   assert_summary_set_R8: assert property (@(posedge clk_ref) disable iff (rst)
      (|los_alarm) |=> alarm_any);

   assert_summary_clear_R8: assert property (@(posedge clk_ref) disable iff (rst)
      !(|los_alarm) |=> !alarm_any);
endmodule

// File: tb/clk_los_monitor_bench.sv
`timescale 1ns/100ps
module clk_los_monitor_bench;
   localparam int NCH  = 2;
   localparam int NMIS = 16;
   localparam int DIV  = 2;
   localparam int HALF = 4;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NCH-1:0] clk_in = '0;
   logic [2*NCH-1:0] mode = '1;
   logic [1:0]     valtime = 2'b00;
   logic [NCH-1:0] los_alarm;
   logic           alarm_any;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit run [NCH];
   int ph [NCH];
   int last_rise [NCH];
   bit mon_on = 1'b0;
   logic prev_or = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   clk_los_monitor #(.NUM_CH(NCH), .MISS_CYC(NMIS), .TICK_DIV(DIV), .SYNC_STAGES(2))
   u_clk_los_monitor (
      .clk_ref(clk), .rst(rst), .clk_in(clk_in), .mode(mode),
      .valtime(valtime), .los_alarm(los_alarm), .alarm_any(alarm_any));

   // input clock generators, driven on the falling reference edge
   always @(negedge clk) begin
      cyc++;
      for (int c = 0; c < NCH; c++) begin
         if (!run[c]) begin
            clk_in[c] = 1'b0;
            ph[c] = 0;
         end else begin
            ph[c]++;
            if (ph[c] == HALF) begin
               ph[c] = 0;
               clk_in[c] = ~clk_in[c];
               if (clk_in[c]) last_rise[c] = cyc;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // R8: summary equals OR of input alarms one cycle earlier
   always @(negedge clk) begin
      #1;
      if (mon_on) chk("R8 summary", alarm_any, prev_or);
      prev_or = |los_alarm;
   end

   task automatic go_to(input int t);
      while (cyc < t) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic stop_ch(input int c, output int lr);
      do begin
         @(negedge clk);
         #1;
      end while (!(clk_in[c] === 1'b1 && last_rise[c] == cyc));
      run[c] = 1'b0;
      lr = last_rise[c];
   endtask

   function automatic int ticks_of(input int sel);
      case (sel)
         0: return 2;
         1: return 100;
         2: return 200;
         default: return 13000;
      endcase
   endfunction

   // kill channel 0, see the alarm rise, restore, check the clearing window
   task automatic loss_and_recover(input int sel);
      int lr, f, n;
      valtime = sel[1:0];
      n = ticks_of(sel);
      stop_ch(0, lr);
      go_to(lr + NMIS + 2);
      chk("R1 alarm low before window", los_alarm[0], 1'b0);
      go_to(lr + NMIS + 3);
      chk("R1 alarm high at window end", los_alarm[0], 1'b1);
      chk("R9 other input untouched", los_alarm[1], 1'b0);
      f = cyc;
      run[0] = 1'b1;
      go_to(f + (n / 2) * DIV);
      chk("R4 alarm held during validation", los_alarm[0], 1'b1);
      go_to(f + (n - 1) * DIV);
      chk("R6 alarm still high before period", los_alarm[0], 1'b1);
      go_to(f + n * DIV);
      chk("R6 alarm clear after period", los_alarm[0], 1'b0);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      int lr, f1, f2, l0, l1, f0, c0;
      for (int c = 0; c < NCH; c++) begin
         run[c] = 1'b1;
         ph[c] = 0;
         last_rise[c] = 0;
      end
      repeat (10) begin
         @(negedge clk);
         #1;
      end
      chk("R7 reset alarm0", los_alarm[0], 1'b0);
      chk("R7 reset alarm1", los_alarm[1], 1'b0);
      chk("R7 reset summary", alarm_any, 1'b0);
      rst = 1'b0;
      mon_on = 1'b1;
      go_to(cyc + 200);
      chk("R7 healthy input0 no alarm", los_alarm[0], 1'b0);
      chk("R7 healthy input1 no alarm", los_alarm[1], 1'b0);

      // R1 R4 R6: all four validation selects in standard mode
      for (int s = 0; s < 4; s++) begin
         loss_and_recover(s);
         go_to(cyc + 40);
      end

      // R2: alternate mode, twice the window
      mode[1:0] = 2'b10;
      valtime = 2'b00;
      go_to(cyc + 40);
      stop_ch(0, lr);
      go_to(lr + NMIS + 3);
      chk("R2 alternate not yet alarmed", los_alarm[0], 1'b0);
      go_to(lr + 2 * NMIS + 2);
      chk("R2 alternate low before window", los_alarm[0], 1'b0);
      go_to(lr + 2 * NMIS + 3);
      chk("R2 alternate high at window end", los_alarm[0], 1'b1);
      f1 = cyc;
      run[0] = 1'b1;
      go_to(f1 + 2 * DIV);
      chk("R2 alternate clears", los_alarm[0], 1'b0);
      mode[1:0] = 2'b11;
      go_to(cyc + 40);

      // R5: fault during validation restarts the period
      valtime = 2'b01;
      stop_ch(0, lr);
      go_to(lr + NMIS + 3);
      chk("R5 first fault", los_alarm[0], 1'b1);
      f1 = cyc;
      run[0] = 1'b1;
      go_to(f1 + 100);
      stop_ch(0, lr);
      f2 = lr + NMIS + 3;
      go_to(f2);
      chk("R5 alarm high at second fault", los_alarm[0], 1'b1);
      run[0] = 1'b1;
      go_to(f1 + 100 * DIV);
      chk("R5 no clear at original deadline", los_alarm[0], 1'b1);
      go_to(f2 + 99 * DIV);
      chk("R5 high before restarted period", los_alarm[0], 1'b1);
      go_to(f2 + 100 * DIV);
      chk("R5 clear after restarted period", los_alarm[0], 1'b0);

      // R3: off and reserved modes
      valtime = 2'b00;
      go_to(cyc + 20);
      stop_ch(0, lr);
      go_to(lr + NMIS + 3);
      chk("R3 alarm set before disable", los_alarm[0], 1'b1);
      mode[1:0] = 2'b00;
      go_to(cyc + 1);
      chk("R3 off mode clears alarm", los_alarm[0], 1'b0);
      go_to(cyc + 60);
      chk("R3 off mode stays low on dead input", los_alarm[0], 1'b0);
      mode[1:0] = 2'b01;
      go_to(cyc + 60);
      chk("R3 reserved mode stays low", los_alarm[0], 1'b0);
      mode[1:0] = 2'b11;
      c0 = cyc;
      go_to(c0 + NMIS - 1);
      chk("R3 full window after enable", los_alarm[0], 1'b0);
      go_to(c0 + NMIS);
      chk("R3 alarm after full window", los_alarm[0], 1'b1);
      f1 = cyc;
      run[0] = 1'b1;
      go_to(f1 + 2 * DIV);
      chk("R3 recovered after re-enable", los_alarm[0], 1'b0);
      go_to(cyc + 40);

      // R8 R9: both inputs alarmed, summary holds until both clear
      valtime = 2'b01;
      stop_ch(0, l0);
      stop_ch(1, l1);
      f0 = l0 + NMIS + 3;
      go_to(f0);
      chk("R9 input0 alarm", los_alarm[0], 1'b1);
      run[0] = 1'b1;
      go_to(f0 + 100);
      chk("R9 input1 alarm", los_alarm[1], 1'b1);
      chk("R8 summary high", alarm_any, 1'b1);
      run[1] = 1'b1;
      go_to(f0 + 100 * DIV);
      chk("R9 input0 cleared alone", los_alarm[0], 1'b0);
      chk("R9 input1 still alarmed", los_alarm[1], 1'b1);
      chk("R8 summary held by input1", alarm_any, 1'b1);
      go_to(f0 + 600);
      chk("R8 input1 cleared", los_alarm[1], 1'b0);
      chk("R8 summary cleared", alarm_any, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule